// File: doc/BRIEF.md
# Two-Street Traffic Controller with Parade Hold

This block drives the signal lights of a crossing between two streets, called street A and street B. It is built from two small cooperating state machines rather than one large one. A light sequencer steps through four light phases: A green, A yellow, B green, B yellow. It is steered by one car sensor per street. A separate two-state mode register holds a parade flag. The sequencer reads that flag only in the B-green phase.

A parade request sets the flag and a resume request clears it. While the flag is set, the sequencer keeps running the normal cycle until it reaches B green, then stays there. Once the flag clears, B green is released in the usual way, when street B has no waiting traffic. Yellow timing, walk signals and sensor filtering are handled elsewhere. Each sensor input is taken as a clean, synchronous level.

Top module: `junction_ctrl`

## Requirements
- R1: A synchronous, active-high reset, sampled on the rising clock edge, puts street A at green, street B at red and the parade flag at 0.
- R2: Each light output is a 2-bit Moore output of the sequencer phase: 00 means green, 01 means yellow, 10 means red. A green shows A=00/B=10, A yellow shows A=01/B=10, B green shows A=10/B=00, B yellow shows A=10/B=01.
- R3: In A green the sequencer stays while `car_a` is 1 and moves to A yellow at the next edge when `car_a` is 0.
- R4: A yellow always moves to B green at the next edge, and B yellow always moves to A green at the next edge.
- R5: In B green the sequencer stays while `car_b` or the registered parade flag is 1. It moves to B yellow at the next edge only when both are 0.
- R6: With the flag at 0, `parade_req`=1 and `resume_req`=0 set `parade_on` to 1 at the next edge.
- R7: With the flag at 1, `resume_req`=1 and `parade_req`=0 clear `parade_on` to 0 at the next edge.
- R8: When `parade_req` and `resume_req` are both 1 in a cycle, or both are 0, `parade_on` keeps its value.
- R9: While the flag is set, the lights finish the normal sequence through A yellow to B green and then hold at B green whatever `car_b` does. After the flag clears, the normal cycle resumes.
- R10: At every cycle at least one street shows red (10).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| car_a | input | 1 | Traffic present on street A |
| car_b | input | 1 | Traffic present on street B |
| parade_req | input | 1 | Request to enter parade mode |
| resume_req | input | 1 | Request to return to regular mode |
| light_a | output | 2 | Street A light code (00 green, 01 yellow, 10 red) |
| light_b | output | 2 | Street B light code (00 green, 01 yellow, 10 red) |
| parade_on | output | 1 | Current mode flag, 1 in parade mode |

## Verification
The outputs are pure decodes of the two registers, so a wrong sequencer phase shows on the light codes in the same cycle it is entered. A wrong mode flag shows on `parade_on` at once. The more subtle fault is a flag that is right at the port but is not consulted by the sequencer. It appears only in B green with `car_b` low, as a B-yellow code one cycle too early. The bench therefore compares every output against a cycle model on every cycle. It uses directed runs through the parade entry and exit and a long stretch of random sensor and request patterns.

// File: rtl/junction_ctrl.sv
module junction_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       car_a,
  input  logic       car_b,
  input  logic       parade_req,
  input  logic       resume_req,
  output logic [1:0] light_a,
  output logic [1:0] light_b,
  output logic       parade_on
);

  localparam logic [1:0] GRN = 2'b00;
  localparam logic [1:0] YEL = 2'b01;
  localparam logic [1:0] RED = 2'b10;

  typedef enum logic [1:0] {PH_AG, PH_AY, PH_BG, PH_BY} phase_t;

  phase_t phase, phase_nx;
  logic   mode_nx;

  always_comb begin
    phase_nx = phase;
    case (phase)
      PH_AG: if (!car_a) phase_nx = PH_AY;
      PH_AY: phase_nx = PH_BG;
      PH_BG: if (!car_b && !parade_on) phase_nx = PH_BY;
      PH_BY: phase_nx = PH_AG;
      default: phase_nx = PH_AG;
    endcase
  end

  assign mode_nx = parade_on ? !(resume_req && !parade_req)
                             : (parade_req && !resume_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_AG;
      parade_on <= 1'b0;
    end else begin
      phase     <= phase_nx;
      parade_on <= mode_nx;
    end
  end

  assign light_a = (phase == PH_AG) ? GRN : (phase == PH_AY) ? YEL : RED;
  assign light_b = (phase == PH_BG) ? GRN : (phase == PH_BY) ? YEL : RED;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (light_a == GRN && light_b == RED && !parade_on));

  // R3
  a_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (light_a == GRN && car_a) |=> light_a == GRN);

  // R4
  a_yellow_step_chk: assert property (@(posedge clk) disable iff (rst)
    (light_a == YEL) |=> (light_a == RED && light_b == GRN));

  // R4
  b_yellow_step_chk: assert property (@(posedge clk) disable iff (rst)
    (light_b == YEL) |=> (light_a == GRN && light_b == RED));

  // R5
  b_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (light_b == GRN && (car_b || parade_on)) |=> light_b == GRN);

  // R6
  mode_set_chk: assert property (@(posedge clk) disable iff (rst)
    (parade_req && !resume_req) |=> parade_on);

  // R7
  mode_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (resume_req && !parade_req) |=> !parade_on);

  // R8
  mode_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (parade_req == resume_req) |=> $stable(parade_on));

  // R10
  one_red_chk: assert property (@(posedge clk) disable iff (rst)
    (light_a == RED || light_b == RED));

endmodule

// File: tb/junction_ctrl_tb_top.sv
module junction_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       car_a, car_b, parade_req, resume_req;
  logic [1:0] light_a, light_b;
  logic       parade_on;

  int n_tests = 0;
  int n_fail  = 0;
  int m_ph    = 0;
  logic m_mode = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  junction_ctrl dut_i (
    .clk(clk), .rst(rst), .car_a(car_a), .car_b(car_b),
    .parade_req(parade_req), .resume_req(resume_req),
    .light_a(light_a), .light_b(light_b), .parade_on(parade_on)
  );

  function automatic int ph_next(int ph, logic a, logic b, logic m);
    case (ph)
      0: return a ? 0 : 1;
      1: return 2;
      2: return (b || m) ? 2 : 3;
      default: return 0;
    endcase
  endfunction

  function automatic logic mode_next(logic m, logic p, logic r);
    if (p && !r) return 1'b1;
    if (r && !p) return 1'b0;
    return m;
  endfunction

  function automatic logic [1:0] code_a(int ph);
    return (ph == 0) ? 2'b00 : (ph == 1) ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [1:0] code_b(int ph);
    return (ph == 2) ? 2'b00 : (ph == 3) ? 2'b01 : 2'b10;
  endfunction

  task automatic chk(string tag);
    n_tests++;
    if (light_a !== code_a(m_ph) || light_b !== code_b(m_ph) || parade_on !== m_mode) begin
      n_fail++;
      $display("FAIL %s: got a=%b b=%b m=%b expected a=%b b=%b m=%b",
               tag, light_a, light_b, parade_on, code_a(m_ph), code_b(m_ph), m_mode);
    end
    n_tests++;
    if (light_a !== 2'b10 && light_b !== 2'b10) begin
      n_fail++;
      $display("FAIL R10: got a=%b b=%b expected one of them 10", light_a, light_b);
    end
  endtask

  task automatic step(logic a, logic b, logic p, logic r, string tag);
    @(negedge clk);
    car_a = a; car_b = b; parade_req = p; resume_req = r;
    @(posedge clk);
    m_ph   = ph_next(m_ph, a, b, m_mode);
    m_mode = mode_next(m_mode, p, r);
    #1;
    chk(tag);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd353));
    rst = 1'b1; car_a = 1'b1; car_b = 1'b0; parade_req = 1'b0; resume_req = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    m_ph = 0; m_mode = 1'b0;
    chk("R1 reset");
    @(negedge clk) rst = 1'b0;

    // R3 hold in A green while traffic on A
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "R3 hold");
    // R6 parade request in A green
    step(1, 0, 1, 0, "R6 set");
    // R3 release, R4 A yellow to B green
    step(0, 0, 0, 0, "R3 advance");
    step(0, 0, 0, 0, "R4 A yellow step");
    // R9 hold at B green under parade, car_b low
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, "R9 parade hold");
    // R8 both requests: mode kept
    step(0, 0, 1, 1, "R8 both");
    // R7 resume
    step(0, 0, 0, 1, "R7 clear");
    step(0, 0, 0, 0, "R5 release");
    step(0, 0, 0, 0, "R4 B yellow step");
    step(1, 0, 0, 0, "R9 resume");
    // R5 hold by car_b in regular mode
    step(0, 1, 0, 0, "R3 advance");
    step(0, 1, 0, 0, "R4 A yellow step");
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, "R5 car_b hold");
    step(0, 0, 0, 0, "R5 release");
    // R8 both with mode clear
    step(1, 0, 1, 1, "R8 both clear");
    step(1, 0, 0, 0, "R8 idle");

    for (int i = 0; i < 3000; i++) begin
      logic a, b, p, r;
      a = ($urandom % 4) != 0;
      b = ($urandom % 3) == 0;
      p = ($urandom % 8) == 0;
      r = ($urandom % 8) == 0;
      step(a, b, p, r, "R2 R3 R4 R5 R6 R7 R8 R9 random");
    end

    // R1 reset mid-run
    @(negedge clk) rst = 1'b1; parade_req = 1'b1;
    @(posedge clk);
    m_ph = 0; m_mode = 1'b0;
    #1;
    chk("R1 reset mid-run");
    @(negedge clk) rst = 1'b0; parade_req = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule